// File: doc/BRIEF.md
# Streaming RGB to Luma Converter

The block converts packed 8-bit RGB colour into 8-bit gray values, sixteen pixels per transfer. Each accepted input word carries 16 interleaved pixels. The block splits the word into red, green and blue planes and zero-extends each channel. For every pixel it forms the weighted sum with Rec.709 weights in Q15 fixed point, then adds one half and shifts out the fraction. The result is clamped to 8 bits, and the 16 gray bytes leave on a single output word.

Both sides of the block use valid/ready handshakes. The datapath is a fixed three-stage pipeline: unpack, multiply-accumulate, then round and saturate. When the consumer keeps ready high, the block accepts one word per cycle. A low output ready freezes all three stages together, and input ready falls whenever the pipeline cannot advance.

Top module: `luma_stream`

## Requirements
- R1: Input byte j sits in `in_data[8j+7:8j]`. Byte 3k is the red channel of pixel k, byte 3k+1 its green channel and byte 3k+2 its blue channel, for k = 0..15.
- R2: Each gray value equals (6966·R + 23436·G + 2366·B + 16384) >> 15. All three products are summed at full precision before this single rounding step.
- R3: The three weights add to exactly 32768. An all-255 pixel therefore gives 255, and an all-0 pixel gives 0.
- R4: Output byte k sits in `out_data[8k+7:8k]` and holds the gray value of pixel k.
- R5: A word accepted at clock edge T appears on `out_valid` after edge T+2 when `out_ready` stays high. Back-to-back words are accepted one per cycle.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` stays stable and `in_ready` is low.
- R7: Every accepted word produces exactly one output word, in acceptance order. No word is dropped or duplicated.
- R8: A synchronous active-high `rst` empties the pipeline. `out_valid` is low after any edge at which `rst` was high.
- R9: The rounded result is clamped to 0..255. No output value ever exceeds 255.
- R10: Channel bytes are unsigned. A red value of 200 with green and blue at 0 gives 43, and a red value of 255 alone gives 54.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word this cycle |
| in_data | input | 384 | 16 interleaved RGB pixels |
| out_valid | output | 1 | Gray word present |
| out_ready | input | 1 | Consumer takes the gray word this cycle |
| out_data | output | 128 | 16 gray bytes in pixel order |

## Verification
The embedded properties check four things on every cycle:
- the held output stays frozen under backpressure, and input ready is low while the output is stalled;
- the pipeline empties after reset;
- the three-edge latency holds when ready stays high;
- every per-lane sum stays inside the Q15 range before clamping, so no lane ever needs clamping.

Only the bench scenarios can show the arithmetic values and the channel positions within a word. They also show that lane k lands in output byte k, and that word order and count survive random backpressure. Unsigned handling of large channel bytes and the one-word-per-cycle rate are likewise shown only by the scenarios.

// File: rtl/luma_pkg.sv
`timescale 1ns/1ps
package luma_pkg;
   // byte position of channel ch (0 red, 1 green, 2 blue) of pixel pix
   function automatic int unsigned chan_byte(input int unsigned pix, input int unsigned ch);
      return 3 * pix + ch;
   endfunction
endpackage

// File: rtl/luma_unpack.sv
`timescale 1ns/1ps
module luma_unpack #(
   parameter int unsigned LANES = 16,
   parameter int unsigned PIX_W = 8,
   parameter int unsigned MUL_W = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic                     v_in,
   input  logic [3*LANES*PIX_W-1:0] pix_in,
   output logic                     v_out,
   output logic [LANES*MUL_W-1:0]   red_pl,
   output logic [LANES*MUL_W-1:0]   grn_pl,
   output logic [LANES*MUL_W-1:0]   blu_pl
);
   import luma_pkg::*;

   logic [LANES*MUL_W-1:0] red_w, grn_w, blu_w;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign red_w[l*MUL_W +: MUL_W] = MUL_W'(pix_in[chan_byte(l, 0)*PIX_W +: PIX_W]);
      assign grn_w[l*MUL_W +: MUL_W] = MUL_W'(pix_in[chan_byte(l, 1)*PIX_W +: PIX_W]);
      assign blu_w[l*MUL_W +: MUL_W] = MUL_W'(pix_in[chan_byte(l, 2)*PIX_W +: PIX_W]);
   end

   always_ff @(posedge clk) begin
      if (rst)     v_out <= 1'b0;
      else if (en) v_out <= v_in;
   end

   always_ff @(posedge clk) begin
      if (en) begin
         red_pl <= red_w;
         grn_pl <= grn_w;
         blu_pl <= blu_w;
      end
   end
endmodule

// File: rtl/luma_mac.sv
`timescale 1ns/1ps
module luma_mac #(
   parameter int unsigned LANES = 16,
   parameter int unsigned PIX_W = 8,
   parameter int unsigned MUL_W = 16,
   parameter int unsigned ACC_W = 32,
   parameter int unsigned FRAC  = 15,
   parameter int unsigned WR    = 6966,
   parameter int unsigned WG    = 23436,
   parameter int unsigned WB    = 2366
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   en,
   input  logic                   v_in,
   input  logic [LANES*MUL_W-1:0] red_pl,
   input  logic [LANES*MUL_W-1:0] grn_pl,
   input  logic [LANES*MUL_W-1:0] blu_pl,
   output logic                   v_out,
   output logic [LANES*ACC_W-1:0] acc
);
   localparam logic [ACC_W-1:0] ACC_LIM = ACC_W'(1) << (PIX_W + FRAC);

   logic [LANES*ACC_W-1:0] sum_w;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [ACC_W-1:0] lane_sum;
      assign lane_sum = ACC_W'(red_pl[l*MUL_W +: MUL_W]) * ACC_W'(WR)
                      + ACC_W'(grn_pl[l*MUL_W +: MUL_W]) * ACC_W'(WG)
                      + ACC_W'(blu_pl[l*MUL_W +: MUL_W]) * ACC_W'(WB);
      assign sum_w[l*ACC_W +: ACC_W] = lane_sum;

      // R2: the unrounded sum must fit the Q15 range of an 8-bit result
      assert_sum_range_R2: assert property (@(posedge clk) disable iff (rst)
         v_in |-> (lane_sum < ACC_LIM));
   end

   always_ff @(posedge clk) begin
      if (rst)     v_out <= 1'b0;
      else if (en) v_out <= v_in;
   end

   always_ff @(posedge clk) begin
      if (en) acc <= sum_w;
   end
endmodule

// File: rtl/luma_round.sv
`timescale 1ns/1ps
module luma_round #(
   parameter int unsigned LANES = 16,
   parameter int unsigned PIX_W = 8,
   parameter int unsigned ACC_W = 32,
   parameter int unsigned FRAC  = 15
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   en,
   input  logic                   v_in,
   input  logic [LANES*ACC_W-1:0] acc,
   output logic                   v_out,
   output logic [LANES*PIX_W-1:0] gray
);
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
   localparam logic [ACC_W-1:0] MAXV = (ACC_W'(1) << PIX_W) - ACC_W'(1);

   logic [LANES*PIX_W-1:0] gray_w;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [ACC_W-1:0] rounded, shifted;
      assign rounded = acc[l*ACC_W +: ACC_W] + HALF;
      assign shifted = rounded >> FRAC;
      assign gray_w[l*PIX_W +: PIX_W] = (shifted > MAXV) ? PIX_W'(MAXV) : PIX_W'(shifted);

      // R9: with weights summing to one, the clamp is never needed
      assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
         v_in |-> (shifted <= MAXV));
   end

   always_ff @(posedge clk) begin
      if (rst)     v_out <= 1'b0;
      else if (en) v_out <= v_in;
   end

   always_ff @(posedge clk) begin
      if (en) gray <= gray_w;
   end
endmodule

// File: rtl/luma_stream.sv
`timescale 1ns/1ps
module luma_stream #(
   parameter int unsigned LANES = 16,
   parameter int unsigned PIX_W = 8,
   parameter int unsigned FRAC  = 15,
   parameter int unsigned ACC_W = 32,
   parameter int unsigned WR    = 6966,
   parameter int unsigned WG    = 23436,
   parameter int unsigned WB    = 2366
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [3*LANES*PIX_W-1:0] in_data,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [LANES*PIX_W-1:0]   out_data
);
   localparam int unsigned MUL_W = 2 * PIX_W;

   if (WR + WG + WB != (1 << FRAC)) begin : g_bad_weights
      $error("luma_stream: weights must sum to 2**FRAC");
   end
   if (ACC_W < PIX_W + FRAC + 1) begin : g_bad_acc
      $error("luma_stream: accumulator too narrow");
   end
   if (LANES == 0) begin : g_bad_lanes
      $error("luma_stream: LANES must be nonzero");
   end

   logic                   adv;
   logic                   v1, v2;
   logic [LANES*MUL_W-1:0] red_pl, grn_pl, blu_pl;
   logic [LANES*ACC_W-1:0] acc;

   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   luma_unpack #(.LANES(LANES), .PIX_W(PIX_W), .MUL_W(MUL_W)) u_unpack (
      .clk(clk), .rst(rst), .en(adv), .v_in(in_valid), .pix_in(in_data),
      .v_out(v1), .red_pl(red_pl), .grn_pl(grn_pl), .blu_pl(blu_pl));

   luma_mac #(.LANES(LANES), .PIX_W(PIX_W), .MUL_W(MUL_W), .ACC_W(ACC_W),
              .FRAC(FRAC), .WR(WR), .WG(WG), .WB(WB)) u_mac (
      .clk(clk), .rst(rst), .en(adv), .v_in(v1),
      .red_pl(red_pl), .grn_pl(grn_pl), .blu_pl(blu_pl),
      .v_out(v2), .acc(acc));

   luma_round #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W), .FRAC(FRAC)) u_round (
      .clk(clk), .rst(rst), .en(adv), .v_in(v2), .acc(acc),
      .v_out(out_valid), .gray(out_data));

   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_stall_block_R6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   assert_reset_empty_R8: assert property (@(posedge clk)
      rst |=> !out_valid);

   assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && out_ready) ##1 out_ready ##1 out_ready |=> out_valid);
endmodule

// File: tb/luma_stream_tb.sv
`timescale 1ns/1ps
module luma_stream_tb;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [383:0] in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit rnd_ready = 1'b0;
   bit hold_low = 1'b0;
   int unsigned lcg = 32'h1234_5678;

   logic [127:0] exp_q[$];
   string        tag_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   luma_stream u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data));

   // {R, G, B, expected gray}, hand-derived from the R2 formula
   localparam logic [31:0] VEC [8] = '{
      {8'd0,   8'd0,   8'd0,   8'd0},
      {8'd255, 8'd255, 8'd255, 8'd255},
      {8'd255, 8'd0,   8'd0,   8'd54},
      {8'd0,   8'd255, 8'd0,   8'd182},
      {8'd0,   8'd0,   8'd255, 8'd18},
      {8'd128, 8'd128, 8'd128, 8'd128},
      {8'd100, 8'd150, 8'd200, 8'd143},
      {8'd10,  8'd20,  8'd30,  8'd19}
   };

   function automatic logic [7:0] ref_gray(input int r, input int g, input int b);
      return 8'((6966 * r + 23436 * g + 2366 * b + 16384) >> 15);
   endfunction

   function automatic int unsigned next_rand();
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      return lcg >> 8;
   endfunction

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [383:0] d, input logic [127:0] e, input string tag);
      in_valid = 1'b1;
      in_data  = d;
      do @(negedge clk); while (!in_ready);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      in_valid = 1'b0;
   endtask

   task automatic drain();
      int n = 0;
      while (exp_q.size() != 0 && n < 200) begin
         @(posedge clk);
         n++;
      end
      repeat (2) @(posedge clk);
      #1;
      check(exp_q.size() == 0, "R7 drain", exp_q.size(), 0);
   endtask

   // lane k uses table entry (k + rot) % 8 (R1, R4)
   task automatic table_beat(input int rot, output logic [383:0] d, output logic [127:0] e);
      for (int k = 0; k < 16; k++) begin
         logic [31:0] v;
         v = VEC[(k + rot) % 8];
         d[24*k +: 8]      = v[31:24];
         d[24*k + 8 +: 8]  = v[23:16];
         d[24*k + 16 +: 8] = v[15:8];
         e[8*k +: 8]       = v[7:0];
      end
   endtask

   task automatic uniform_beat(input int r, input int g, input int b,
                               output logic [383:0] d, output logic [127:0] e);
      for (int k = 0; k < 16; k++) begin
         d[24*k +: 24] = {8'(b), 8'(g), 8'(r)};
         e[8*k +: 8]   = ref_gray(r, g, b);
      end
   endtask

   // output monitor: order, count and values (R2, R4, R7, R9)
   always @(negedge clk) begin
      if (!rst && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected output", longint'(out_data[63:0]), 0);
         end else begin
            logic [127:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(out_data == e, t, longint'(out_data[63:0]), longint'(e[63:0]));
         end
      end
   end

   // out_ready driver, changed away from the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (hold_low)       out_ready = 1'b0;
         else if (rnd_ready) out_ready = next_rand()[0] | next_rand()[1];
         else                out_ready = 1'b1;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [383:0] d;
      logic [127:0] e;
      logic [127:0] held;
      int t0;

      repeat (3) @(posedge clk);
      #1;
      // R8: reset state
      check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
      rst = 1'b0;
      @(posedge clk);
      #1;
      check(in_ready == 1'b1, "R8 in_ready after reset", in_ready, 1);

      // R5: latency of an isolated word
      table_beat(0, d, e);
      send(d, e, "R5 latency data");
      idle();
      check(out_valid == 1'b0, "R5 not early T+0", out_valid, 0);
      @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R5 not early T+1", out_valid, 0);
      @(posedge clk);
      #1;
      check(out_valid == 1'b1, "R5 valid at T+2", out_valid, 1);
      drain();

      // R1 R2 R4: table vectors, rotated across lanes, back-to-back
      @(posedge clk);
      #1;
      t0 = cyc;
      for (int rot = 0; rot < 8; rot++) begin
         table_beat(rot, d, e);
         send(d, e, "R2/R4 table vector");
      end
      idle();
      check(cyc - t0 == 8, "R5 one word per cycle", cyc - t0, 8);
      drain();

      // R3: white and black
      uniform_beat(255, 255, 255, d, e);
      send(d, e, "R3 white");
      uniform_beat(0, 0, 0, d, e);
      send(d, e, "R3 black");
      idle();
      drain();

      // R10: unsigned channels
      uniform_beat(200, 0, 0, d, e);
      check(e[7:0] == 8'd43, "R10 reference red 200", e[7:0], 43);
      send(d, e, "R10 red 200");
      uniform_beat(0, 0, 200, d, e);
      send(d, e, "R10 blue 200");
      idle();
      drain();

      // R6: stall holds data and blocks input
      hold_low = 1'b1;
      @(posedge clk);
      #1;
      for (int i = 0; i < 3; i++) begin
         table_beat(i + 3, d, e);
         send(d, e, "R6/R7 stalled word");
      end
      idle();
      @(negedge clk);
      check(out_valid == 1'b1, "R6 valid while stalled", out_valid, 1);
      check(in_ready == 1'b0, "R6 in_ready low while stalled", in_ready, 0);
      held = out_data;
      repeat (4) @(negedge clk);
      check(out_data == held, "R6 data stable", longint'(out_data[63:0]), longint'(held[63:0]));
      hold_low = 1'b0;
      drain();

      // R7 R9: random pixels with random backpressure
      rnd_ready = 1'b1;
      for (int w = 0; w < 40; w++) begin
         for (int k = 0; k < 16; k++) begin
            int r, g, b;
            r = int'(next_rand() & 255);
            g = int'(next_rand() & 255);
            b = int'(next_rand() & 255);
            d[24*k +: 24] = {8'(b), 8'(g), 8'(r)};
            e[8*k +: 8]   = ref_gray(r, g, b);
         end
         send(d, e, "R7/R9 random stream");
         if (next_rand()[2]) begin
            idle();
            @(posedge clk);
            #1;
         end
      end
      idle();
      rnd_ready = 1'b0;
      drain();

      // R8: reset in the middle of a stream
      table_beat(1, d, e);
      send(d, e, "R8 flushed");
      send(d, e, "R8 flushed");
      idle();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R8 mid-stream reset", out_valid, 0);
      exp_q.delete();
      tag_q.delete();
      rst = 1'b0;
      repeat (5) @(posedge clk);
      #1;
      check(out_valid == 1'b0, "R8 nothing emerges after flush", out_valid, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule